// File: doc/BRIEF.md
# Dual Decade Counter

The block holds two four-bit decade counters, each split into a one-bit divide-by-2 section and a three-bit divide-by-5 section. Every section has its own count input, and a section advances when that input goes from high to low. All count inputs are asynchronous to the block. Each is passed through a synchronizer and an edge detector that run on one system clock, so all state changes happen on that clock.

A two-bit mode per counter selects how its two sections are joined. In split mode the sections count on their own. In BCD mode pulses enter the divide-by-2 section, and its falling output steps the divide-by-5 section, so the counter shows binary 0 to 9. In bi-quinary mode pulses enter the divide-by-5 section, and its wrap steps the divide-by-2 section. This gives a non-binary order in which bit 0 is a square wave at one tenth of the input rate. A cascade bit sends the carry of counter A into counter B in place of counter B's own entry input. This allows overall ratios such as 20, 25, 50 and 100. Each counter has its own active-high asynchronous clear.

Top module: `dual_decade_counter`

## Requirements
- R1: While a counter's clear input is high, all four of its outputs are 0, from the moment the clear rises and without waiting for a clock edge. The other counter keeps its value.
- R2: A section advances only on a high-to-low change of its count input. A low-to-high change leaves the outputs unchanged.
- R3: The divide-by-5 section, shown as the binary value q[3:1], steps 0,1,2,3,4 and then returns to 0. It never holds a value above 4.
- R4: In mode 2'b00 (split), q[0] toggles on each falling edge of the low count input, and q[3:1] steps only on falling edges of the high count input.
- R5: In mode 2'b01 (BCD), falling edges of the low count input step q through binary 0 to 9 and back to 0, one step per edge. The high count input has no effect.
- R6: In mode 2'b10 (bi-quinary), falling edges of the high count input step the counter through q = 0000, 0010, 0100, 0110, 1000, 0001, 0011, 0101, 0111, 1001 (written q[3:0]). q[0] changes only when q[3:1] wraps from 4 to 0, and it is high for 5 of every 10 counts.
- R7: With cascade set, counter B takes one step each time counter A's carry falls. The carry is q[0] of A in bi-quinary mode and q[3] of A in the other modes. With both counters in BCD mode, b_q[3] divides the input by 100.
- R8: With cascade set, counter B's own entry input is ignored. The entry input is the high input in bi-quinary mode and the low input otherwise.
- R9: Edges on a count input while its counter is cleared are discarded. After the clear is released, the first counted event is the next falling edge of that input.
- R10: Mode 2'b11 behaves exactly like mode 2'b00.
- R11: The output bits divide their input by 2, 5, 10, 20, 25, 50 and 100 in the configurations that produce those ratios.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all count inputs |
| clr_a | input | 1 | Asynchronous active-high clear of counter A |
| clr_b | input | 1 | Asynchronous active-high clear of counter B |
| a_tick_lo | input | 1 | Count input of counter A's divide-by-2 section |
| a_tick_hi | input | 1 | Count input of counter A's divide-by-5 section |
| b_tick_lo | input | 1 | Count input of counter B's divide-by-2 section |
| b_tick_hi | input | 1 | Count input of counter B's divide-by-5 section |
| a_mode | input | 2 | Wiring of counter A: 00 split, 01 BCD, 10 bi-quinary, 11 as split |
| b_mode | input | 2 | Wiring of counter B, same encoding |
| cascade | input | 1 | Sends counter A's carry into counter B's entry input |
| a_q | output | 4 | Counter A state: q[0] divide-by-2 bit, q[3:1] divide-by-5 value |
| b_q | output | 4 | Counter B state, same layout |

## Verification
On every cycle, the assertions check that a clear forces zero and that the divide-by-5 value stays at or below 4. They also check that each BCD change is a single step modulo 10, that the bi-quinary low bit moves only on a quinary wrap, and that a cascaded counter B moves only when counter A wraps from 9 to 0. The bench scenarios are needed for the rest. These are the exact bi-quinary code order, the fact that rising edges and the bypassed entry inputs are ignored, the discarding of edges during clear, the equivalence of the reserved mode with split mode, and the divide ratios measured over 200 input pulses.

// File: rtl/ddc_pkg.sv
package ddc_pkg;

    typedef enum logic [1:0] {
        MODE_SPLIT = 2'b00,
        MODE_BCD   = 2'b01,
        MODE_BIQ   = 2'b10,
        MODE_RSVD  = 2'b11
    } ddc_mode_e;

    localparam int unsigned QUIN_W    = 3;
    localparam int unsigned QUIN_LAST = 4;

    typedef struct packed {
        logic [QUIN_W-1:0] hi;
        logic              lo;
    } ddc_state_t;

endpackage

// File: rtl/ddc_fall_detect.sv
module ddc_fall_detect #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic clr,
    input  logic din,
    output logic fall
);

    typedef struct packed {
        logic [STAGES-1:0] sync;
        logic              last;
    } det_t;

    det_t det_d, det_q;

    always_comb begin
        det_d      = det_q;
        det_d.sync = {det_q.sync[STAGES-2:0], din};
        det_d.last = det_q.sync[STAGES-1];
    end

    always_ff @(posedge clk or posedge clr) begin
        if (clr) begin
            det_q <= '0;
        end else begin
            det_q <= det_d;
        end
    end

    assign fall = det_q.last & ~det_q.sync[STAGES-1];

endmodule

// File: rtl/ddc_decade.sv
module ddc_decade
    import ddc_pkg::*;
(
    input  logic       clk,
    input  logic       clr,
    input  logic       fall_lo,
    input  logic       fall_hi,
    input  logic [1:0] mode,
    output logic [3:0] q,
    output logic       carry
);

    ddc_state_t st_d, st_q;
    logic       step_lo;
    logic       step_hi;
    logic       hi_wrap;

    assign hi_wrap = (st_q.hi == QUIN_W'(QUIN_LAST));

    always_comb begin
        step_lo = fall_lo;
        step_hi = fall_hi;
        carry   = 1'b0;
        case (mode)
            MODE_BCD: begin
                step_lo = fall_lo;
                step_hi = fall_lo & st_q.lo;
            end
            MODE_BIQ: begin
                step_hi = fall_hi;
                step_lo = fall_hi & hi_wrap;
            end
            default: begin
                step_lo = fall_lo;
                step_hi = fall_hi;
            end
        endcase

        if (mode == MODE_BIQ) begin
            carry = step_lo & st_q.lo;
        end else begin
            carry = step_hi & hi_wrap;
        end

        st_d = st_q;
        if (step_lo) begin
            st_d.lo = ~st_q.lo;
        end
        if (step_hi) begin
            st_d.hi = hi_wrap ? '0 : st_q.hi + 1'b1;
        end
    end

    always_ff @(posedge clk or posedge clr) begin
        if (clr) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign q = st_q;

endmodule

// File: rtl/dual_decade_counter.sv
module dual_decade_counter
    import ddc_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       clr_a,
    input  logic       clr_b,
    input  logic       a_tick_lo,
    input  logic       a_tick_hi,
    input  logic       b_tick_lo,
    input  logic       b_tick_hi,
    input  logic [1:0] a_mode,
    input  logic [1:0] b_mode,
    input  logic       cascade,
    output logic [3:0] a_q,
    output logic [3:0] b_q
);

    localparam int unsigned N_CNT = 2;
    localparam int unsigned N_IN  = 2 * N_CNT;

    logic [N_IN-1:0] tick_raw;
    logic [N_IN-1:0] tick_clr;
    logic [N_IN-1:0] tick_fall;

    logic a_carry;
    logic b_carry;
    logic b_fall_lo;
    logic b_fall_hi;
    logic unused_tail_carry;

    assign tick_raw = {b_tick_hi, b_tick_lo, a_tick_hi, a_tick_lo};
    assign tick_clr = {clr_b, clr_b, clr_a, clr_a};

    for (genvar gi = 0; gi < N_IN; gi++) begin : g_in
        ddc_fall_detect #(
            .STAGES(SYNC_STAGES)
        ) u_det (
            .clk (clk),
            .clr (tick_clr[gi]),
            .din (tick_raw[gi]),
            .fall(tick_fall[gi])
        );
    end

    ddc_decade u_cnt_a (
        .clk    (clk),
        .clr    (clr_a),
        .fall_lo(tick_fall[0]),
        .fall_hi(tick_fall[1]),
        .mode   (a_mode),
        .q      (a_q),
        .carry  (a_carry)
    );

    always_comb begin
        b_fall_lo = tick_fall[2];
        b_fall_hi = tick_fall[3];
        if (cascade) begin
            if (b_mode == MODE_BIQ) begin
                b_fall_hi = a_carry;
            end else begin
                b_fall_lo = a_carry;
            end
        end
    end

    ddc_decade u_cnt_b (
        .clk    (clk),
        .clr    (clr_b),
        .fall_lo(b_fall_lo),
        .fall_hi(b_fall_hi),
        .mode   (b_mode),
        .q      (b_q),
        .carry  (b_carry)
    );

    assign unused_tail_carry = b_carry;

endmodule

// File: rtl/ddc_checker.sv
module ddc_checker (
    input logic       clk,
    input logic       clr_a,
    input logic       clr_b,
    input logic [1:0] a_mode,
    input logic [1:0] b_mode,
    input logic       cascade,
    input logic [3:0] a_q,
    input logic [3:0] b_q
);

    AST_CLEAR_A: assert property (@(posedge clk)
        clr_a |-> (a_q == 4'd0)); // R1

    AST_CLEAR_B: assert property (@(posedge clk)
        clr_b |-> (b_q == 4'd0)); // R1

    AST_QUIN_RANGE_A: assert property (@(posedge clk) disable iff (clr_a)
        a_q[3:1] <= 3'd4); // R3

    AST_QUIN_RANGE_B: assert property (@(posedge clk) disable iff (clr_b)
        b_q[3:1] <= 3'd4); // R3

    AST_BCD_STEP: assert property (@(posedge clk) disable iff (clr_a)
        (a_mode == 2'b01 && $past(a_mode) == 2'b01 && a_q != $past(a_q))
        |-> (a_q == (($past(a_q) == 4'd9) ? 4'd0 : $past(a_q) + 4'd1))); // R5

    AST_BIQ_LOW_BIT: assert property (@(posedge clk) disable iff (clr_a)
        (a_mode == 2'b10 && $past(a_mode) == 2'b10 && a_q[0] != $past(a_q[0]))
        |-> ($past(a_q[3:1]) == 3'd4 && a_q[3:1] == 3'd0)); // R6

    AST_CASCADE_STEP: assert property (@(posedge clk) disable iff (clr_a || clr_b)
        (cascade && $past(cascade) && a_mode == 2'b01 && $past(a_mode) == 2'b01
         && b_mode == 2'b01 && $past(b_mode) == 2'b01 && b_q != $past(b_q))
        |-> ($past(a_q) == 4'd9 && a_q == 4'd0)); // R7

endmodule

bind dual_decade_counter ddc_checker u_ddc_checker (
    .clk    (clk),
    .clr_a  (clr_a),
    .clr_b  (clr_b),
    .a_mode (a_mode),
    .b_mode (b_mode),
    .cascade(cascade),
    .a_q    (a_q),
    .b_q    (b_q)
);

// File: tb/dual_decade_counter_bench.sv
module dual_decade_counter_bench;

    logic       clk = 1'b0;
    logic       clr_a, clr_b;
    logic       a_tick_lo, a_tick_hi, b_tick_lo, b_tick_hi;
    logic [1:0] a_mode, b_mode;
    logic       cascade;
    logic [3:0] a_q, b_q;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    dual_decade_counter u_dual_decade_counter (
        .clk      (clk),
        .clr_a    (clr_a),
        .clr_b    (clr_b),
        .a_tick_lo(a_tick_lo),
        .a_tick_hi(a_tick_hi),
        .b_tick_lo(b_tick_lo),
        .b_tick_hi(b_tick_hi),
        .a_mode   (a_mode),
        .b_mode   (b_mode),
        .cascade  (cascade),
        .a_q      (a_q),
        .b_q      (b_q)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // src: 0 a_lo, 1 a_hi, 2 b_lo, 3 b_hi
    task automatic drive(input int src, input logic v);
        case (src)
            0: a_tick_lo = v;
            1: a_tick_hi = v;
            2: b_tick_lo = v;
            default: b_tick_hi = v;
        endcase
    endtask

    task automatic pulse(input int src);
        drive(src, 1'b1);
        repeat (4) @(negedge clk);
        drive(src, 1'b0);
        repeat (4) @(negedge clk);
    endtask

    task automatic setup(input logic [1:0] ma, input logic [1:0] mb, input logic cas);
        @(negedge clk);
        a_tick_lo = 0; a_tick_hi = 0; b_tick_lo = 0; b_tick_hi = 0;
        a_mode = ma; b_mode = mb; cascade = cas;
        clr_a = 1; clr_b = 1;
        repeat (3) @(negedge clk);
        clr_a = 0; clr_b = 0;
        repeat (3) @(negedge clk);
    endtask

    // bi-quinary table written Q0Q1Q2Q3, returned as q[3:0]
    function automatic logic [3:0] biq_code(input int n);
        logic [3:0] lit;
        case (n)
            0: lit = 4'b0000; 1: lit = 4'b0100; 2: lit = 4'b0010; 3: lit = 4'b0110;
            4: lit = 4'b0001; 5: lit = 4'b1000; 6: lit = 4'b1100; 7: lit = 4'b1010;
            8: lit = 4'b1110; default: lit = 4'b1001;
        endcase
        return {lit[0], lit[1], lit[2], lit[3]};
    endfunction

    task automatic t_reset_state;
        setup(2'b00, 2'b00, 1'b0);
        check("R1 reset state a_q", int'(a_q), 0);
        check("R1 reset state b_q", int'(b_q), 0);
    endtask

    task automatic t_split;
        setup(2'b00, 2'b00, 1'b0);
        pulse(0);
        check("R4 split low toggles", int'(a_q), 1);
        a_tick_hi = 1;
        repeat (6) @(negedge clk);
        check("R2 rising edge ignored", int'(a_q), 1);
        a_tick_hi = 0;
        repeat (4) @(negedge clk);
        check("R4 split high steps", int'(a_q), 3);
        for (int k = 2; k <= 6; k++) begin
            pulse(1);
            check("R3 quinary sequence", int'(a_q[3:1]), k % 5);
        end
        pulse(0);
        check("R4 split low back to 0", int'(a_q[0]), 0);
    endtask

    task automatic t_bcd;
        setup(2'b01, 2'b00, 1'b0);
        for (int k = 1; k <= 12; k++) begin
            pulse(0);
            check("R5 bcd count", int'(a_q), k % 10);
        end
        pulse(1);
        check("R5 bcd ignores high input", int'(a_q), 2);
    endtask

    task automatic t_biq;
        int highs;
        highs = 0;
        setup(2'b10, 2'b00, 1'b0);
        for (int k = 1; k <= 12; k++) begin
            pulse(1);
            check("R6 biquinary code", int'(a_q), int'(biq_code(k % 10)));
            if (k <= 10 && a_q[0]) highs++;
        end
        check("R6 low bit high half", highs, 5);
        pulse(0);
        check("R6 biquinary ignores low input", int'(a_q), int'(biq_code(2)));
    endtask

    task automatic t_reserved;
        setup(2'b11, 2'b00, 1'b0);
        pulse(0);
        check("R10 reserved low input", int'(a_q), 1);
        pulse(1);
        check("R10 reserved high input", int'(a_q), 3);
    endtask

    task automatic t_async_clear;
        setup(2'b01, 2'b01, 1'b0);
        repeat (7) pulse(0);
        repeat (3) pulse(2);
        check("R1 pre-clear count", int'(a_q), 7);
        @(negedge clk);
        #1 clr_a = 1;
        #0.5;
        check("R1 clear is immediate", int'(a_q), 0);
        check("R1 other counter kept", int'(b_q), 3);
        @(negedge clk);
        clr_a = 0;
        repeat (3) @(negedge clk);
    endtask

    task automatic t_reset_discard;
        setup(2'b01, 2'b00, 1'b0);
        clr_a = 1;
        repeat (3) pulse(0);
        clr_a = 0;
        repeat (4) @(negedge clk);
        check("R9 edges in clear discarded", int'(a_q), 0);
        clr_a = 1;
        a_tick_lo = 1;
        repeat (2) @(negedge clk);
        clr_a = 0;
        repeat (4) @(negedge clk);
        a_tick_lo = 0;
        repeat (4) @(negedge clk);
        check("R9 first falling edge counted", int'(a_q), 1);
    endtask

    task automatic t_cascade;
        setup(2'b01, 2'b01, 1'b1);
        repeat (23) pulse(0);
        check("R7 cascade a digit", int'(a_q), 3);
        check("R7 cascade b digit", int'(b_q), 2);
        pulse(2);
        check("R8 cascade ignores b entry", int'(b_q), 2);
        setup(2'b00, 2'b10, 1'b1);
        pulse(3);
        check("R8 cascade ignores b high entry", int'(b_q), 0);
    endtask

    task automatic measure(input logic [1:0] ma, input logic [1:0] mb, input logic cas,
                           input int src, input int cnt, input int bitn, input int ratio);
        int falls;
        logic prev, cur;
        falls = 0;
        setup(ma, mb, cas);
        prev = 1'b0;
        for (int k = 0; k < 200; k++) begin
            pulse(src);
            cur = (cnt == 0) ? a_q[bitn] : b_q[bitn];
            if (prev && !cur) falls++;
            prev = cur;
        end
        check($sformatf("R11 divide by %0d", ratio), falls, 200 / ratio);
    endtask

    task automatic t_divide;
        measure(2'b00, 2'b00, 1'b0, 0, 0, 0, 2);
        measure(2'b00, 2'b00, 1'b0, 1, 0, 3, 5);
        measure(2'b01, 2'b00, 1'b0, 0, 0, 3, 10);
        measure(2'b10, 2'b00, 1'b0, 1, 0, 0, 10);
        measure(2'b01, 2'b00, 1'b1, 0, 1, 0, 20);
        measure(2'b00, 2'b10, 1'b1, 1, 1, 3, 25);
        measure(2'b00, 2'b10, 1'b1, 1, 1, 0, 50);
        measure(2'b01, 2'b01, 1'b1, 0, 1, 3, 100); // R7
    endtask

    task automatic finish_run;
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        clr_a = 1; clr_b = 1;
        a_tick_lo = 0; a_tick_hi = 0; b_tick_lo = 0; b_tick_hi = 0;
        a_mode = 2'b00; b_mode = 2'b00; cascade = 1'b0;
        t_reset_state();
        t_split();
        t_bcd();
        t_biq();
        t_reserved();
        t_async_clear();
        t_reset_discard();
        t_cascade();
        t_divide();
        finish_run();
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

endmodule